// File: doc/BRIEF.md
# Programmable Clock Divider with Lock Handshake

This block produces a divided clock from its input clock. One 32-bit configuration word sets the division. It holds separate counts for the low phase and the high phase, a half-cycle stretch bit for odd ratios, a pass-through bit and a hold bit. Software writes the word and then polls a lock flag. The flag drops as soon as a write is accepted. It rises again only after the new setting is running and one full period of it has been produced.

A new setting takes effect only at the boundary between two output periods, so a change of ratio never produces a truncated pulse. A write with the hold bit set has no effect on the output or on the flag.

The controller is a three-state machine. Its states are LOCKED (the flag is high and the running setting is stable), WAIT (a setting has been accepted and waits for the current output period to end) and SETTLE (the new setting has been applied and the first full period of it is running). The transitions are:
- **accept**: from any state to WAIT, on a write with the hold bit clear.
- **apply**: from WAIT to SETTLE, at an output period boundary.
- **settled**: from SETTLE to LOCKED, at the next output period boundary.

Top module: `clkdiv_hs`

## Requirements
- R1: The configuration word uses these bit positions: low count in bits 5..0, high count in bits 11..6, stretch bit in bit 12, pass-through bit in bit 13 and hold bit in bit 14. Bits 31..15 are ignored.
- R2: After reset the divider is in pass-through mode and the lock flag is 1.
- R3: In pass-through mode `clk_out` follows `clk_in`. The high time is half an input cycle and the period is one input cycle.
- R4: With the stretch bit at 0, the output is high for (high count) input cycles and low for (low count) input cycles. The period is low count plus high count.
- R5: With the stretch bit at 1, the high time is (high count + 0.5) input cycles and the period is still low count plus high count. With low count one above high count, an odd ratio gives a near-50% duty cycle.
- R6: A low count or high count of 0 acts as 1.
- R7: A write with the hold bit at 0 makes the lock flag 0 from the next clock edge.
- R8: An accepted setting is applied only at the end of a complete output period. The lock flag stays 0 through one full period of the new setting and returns to 1 at a period boundary. The time with the flag at 0 lies between N_new+1 and N_old+N_new input cycles, at most 252 cycles.
- R9: A write with the hold bit at 1 leaves the running output clock and the lock flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Configuration write strobe, one cycle |
| wr_data | input | 32 | Configuration word |
| clk_out | output | 1 | Divided output clock |
| lock | output | 1 | 1 when the running setting is settled |

## Verification
Each fault in the block shows at the ports within about two output periods:
- **Stuck state machine.** The lock flag fails to fall on the edge after an accepted write, or fails to rise within the bounded window.
- **Setting applied at the wrong time.** The first period after the flag rises has the wrong length.
- **Wrong phase counter.** The measured high time or period of `clk_out` is wrong.
- **Dropped stretch half-cycle.** The high time of an odd ratio is off by half an input cycle, which the edge-time measurement resolves.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
    localparam int FW        = 6;
    localparam int TW        = FW + 1;
    localparam int HI_LSB    = FW;
    localparam int STR_BIT   = 2 * FW;
    localparam int BYP_BIT   = 2 * FW + 1;
    localparam int NOUPD_BIT = 2 * FW + 2;

    // Packed so that the struct maps directly onto word bits BYP_BIT..0
    typedef struct packed {
        logic          bypass;
        logic          stretch;
        logic [FW-1:0] hi;
        logic [FW-1:0] lo;
    } div_cfg_t;

    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_WAIT   = 2'd1,
        ST_SETTLE = 2'd2
    } ctl_state_t;

    localparam div_cfg_t RESET_CFG = '{bypass: 1'b1, stretch: 1'b0, hi: '0, lo: '0};

    function automatic logic [FW-1:0] eff_count(input logic [FW-1:0] c);
        return (c == '0) ? FW'(1) : c;
    endfunction
endpackage

// File: rtl/clkdiv_ctrl.sv
`timescale 1ns/1ps
module clkdiv_ctrl
    import clkdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [NOUPD_BIT:0] wr_word,
    input  logic               wrap,
    output div_cfg_t           active_cfg,
    output logic               lock
);
    ctl_state_t st_q, st_d;
    div_cfg_t   pend_q;
    logic       accept, apply;

    assign accept = wr_en & ~wr_word[NOUPD_BIT];

    // next-state logic
    always_comb begin
        st_d  = st_q;
        apply = 1'b0;
        unique case (st_q)
            ST_LOCKED: ;
            ST_WAIT: begin
                if (wrap) begin
                    st_d  = ST_SETTLE;
                    apply = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (wrap) st_d = ST_LOCKED;
            end
            default: st_d = ST_LOCKED;
        endcase
        if (accept) begin
            st_d  = ST_WAIT;
            apply = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_LOCKED;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q     <= RESET_CFG;
            active_cfg <= RESET_CFG;
        end else begin
            if (accept) pend_q     <= div_cfg_t'(wr_word[BYP_BIT:0]);
            if (apply)  active_cfg <= pend_q;
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            ST_LOCKED: lock = 1'b1;
            ST_WAIT:   lock = 1'b0;
            ST_SETTLE: lock = 1'b0;
            default:   lock = 1'b0;
        endcase
    end
endmodule

// File: rtl/clkdiv_gen.sv
`timescale 1ns/1ps
module clkdiv_gen
    import clkdiv_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  div_cfg_t cfg,
    output logic     wrap,
    output logic     clk_out
);
    logic [TW-1:0] cnt_q, hi_w, total;
    logic          q_pos, q_neg;

    assign hi_w  = {1'b0, eff_count(cfg.hi)};
    assign total = {1'b0, eff_count(cfg.lo)} + hi_w;
    assign wrap  = cfg.bypass | (cnt_q == total - 1'b1);

    // phase counter and rising-edge output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            q_pos <= 1'b1;
        end else if (wrap) begin
            cnt_q <= '0;
            q_pos <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            q_pos <= (cnt_q + 1'b1) < hi_w;
        end
    end

    // half-cycle delayed copy for the stretched high phase
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) q_neg <= 1'b1;
        else        q_neg <= q_pos;
    end

    always_comb begin
        if (cfg.bypass)       clk_out = clk;
        else if (cfg.stretch) clk_out = q_pos | q_neg;
        else                  clk_out = q_pos;
    end
endmodule

// File: rtl/clkdiv_hs.sv
`timescale 1ns/1ps
module clkdiv_hs
    import clkdiv_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk_in,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              clk_out,
    output logic              lock
);
    localparam int USED_W = NOUPD_BIT + 1;

    div_cfg_t active_cfg;
    logic     wrap;
    logic     pad_unused;

    assign pad_unused = ^wr_data[WORD_W-1:USED_W];

    clkdiv_ctrl u_ctrl (
        .clk       (clk_in),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_word   (wr_data[USED_W-1:0]),
        .wrap      (wrap),
        .active_cfg(active_cfg),
        .lock      (lock)
    );

    clkdiv_gen u_gen (
        .clk    (clk_in),
        .rst_n  (rst_n),
        .cfg    (active_cfg),
        .wrap   (wrap),
        .clk_out(clk_out)
    );
endmodule

// File: rtl/clkdiv_chk.sv
`timescale 1ns/1ps
module clkdiv_chk (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic                  wr_noupd,
    input logic                  wrap,
    input logic                  lock,
    input clkdiv_pkg::div_cfg_t  active_cfg
);
    // R7
    lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_noupd) |=> !lock);

    // R9
    hold_keeps_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && wr_en && wr_noupd) |=> lock);

    // R8
    relock_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> $past(wrap));

    // R8
    apply_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_cfg) |-> $past(wrap));
endmodule

bind clkdiv_hs clkdiv_chk chk_i (
    .clk       (clk_in),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_noupd  (wr_data[clkdiv_pkg::NOUPD_BIT]),
    .wrap      (wrap),
    .lock      (lock),
    .active_cfg(active_cfg)
);

// File: tb/clkdiv_hs_tb_top.sv
`timescale 1ns/1ps
module clkdiv_hs_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [31:0] wr_data;
    logic        clk_out;
    logic        lock;

    int checks = 0;
    int fails  = 0;
    int cur_n  = 1;

    clkdiv_hs dut_i (
        .clk_in (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .clk_out(clk_out),
        .lock   (lock)
    );

    always #(HALF) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: run hung, actual=%0d expected=%0d", 0, 1);
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // R1 encoding: lo[5:0], hi[11:6], stretch 12, bypass 13, hold 14
    function automatic logic [31:0] enc(input int n, input bit hold);
        logic [31:0] w = '0;
        int hi = n / 2;
        int lo = (n % 2 == 0) ? n / 2 : n / 2 + 1;
        w[5:0]  = lo[5:0];
        w[11:6] = hi[5:0];
        w[12]   = (n % 2 == 1);
        w[13]   = (n == 1);
        w[14]   = hold;
        return w;
    endfunction

    task automatic do_write(input logic [31:0] w);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic measure(input int exp_hi, input int exp_per, input string req);
        realtime t0, t1, t2;
        @(posedge clk_out); t0 = $realtime;
        @(negedge clk_out); t1 = $realtime;
        @(posedge clk_out); t2 = $realtime;
        check(int'(t1 - t0) == exp_hi, req, "high time", int'(t1 - t0), exp_hi);
        check(int'(t2 - t0) == exp_per, req, "period", int'(t2 - t0), exp_per);
    endtask

    // write, check lock handshake, then measure output
    task automatic switch_to(input logic [31:0] w, input int n, input int exp_hi,
                             input string req);
        int lowcnt = 0;
        do_write(w);
        check(lock == 1'b0, "R7", "lock after write", int'(lock), 0);
        while (lock == 1'b0 && lowcnt < 5000) begin
            lowcnt++;
            @(negedge clk);
        end
        check(lowcnt >= n + 1, "R8", "lock low cycles min", lowcnt, n + 1);
        check(lowcnt <= cur_n + n, "R8", "lock low cycles max", lowcnt, cur_n + n);
        cur_n = n;
        measure(exp_hi, n * CLK_PERIOD, req);
    endtask

    initial begin
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(lock == 1'b1, "R2", "lock after reset", int'(lock), 1);
        measure(HALF, CLK_PERIOD, "R3");

        // R4 even ratio
        switch_to(enc(2, 1'b0), 2, 1 * CLK_PERIOD, "R4");
        // R5 odd ratio, stretch
        switch_to(enc(3, 1'b0), 3, 1 * CLK_PERIOD + HALF, "R5");
        // R4 larger even
        switch_to(enc(10, 1'b0), 10, 5 * CLK_PERIOD, "R4");
        // R5 large odd
        switch_to(enc(45, 1'b0), 45, 22 * CLK_PERIOD + HALF, "R5");

        // R9 hold write ignored; R1 pad bits set too
        begin
            int lock_drops = 0;
            do_write(enc(3, 1'b1) | 32'hFFFF_8000);
            for (int i = 0; i < 300; i++) begin
                if (lock != 1'b1) lock_drops++;
                @(negedge clk);
            end
            check(lock_drops == 0, "R9", "lock drops after hold write", lock_drops, 0);
            measure(22 * CLK_PERIOD + HALF, 45 * CLK_PERIOD, "R9");
        end

        // R3 ratio 1 by pass-through
        switch_to(enc(1, 1'b0), 1, HALF, "R3");
        // R6 zero counts act as 1: ratio 2, stretch 0; R1 pad bits ignored
        switch_to(32'hABCD_0000 & 32'hFFFF_8000, 2, 1 * CLK_PERIOD, "R6");
        // R1 raw word: lo=4 hi=2 stretch=0 -> period 6, high 2
        switch_to(32'h0000_0084, 6, 2 * CLK_PERIOD, "R1");

        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule